// File: doc/BRIEF.md
# Ethernet MAC statistics counter bank

This block keeps running statistics for an Ethernet MAC and serves them through a small 32-bit register port. It holds a 48-bit count of octets in good received frames and a 10-bit count of carrier-sense errors on transmitted frames. The MAC receive and transmit paths feed it one strobe for each frame. The receive strobe carries a byte count. The transmit strobe carries qualifier flags that describe how carrier sense behaved during that frame.

Every counter stops at all ones instead of wrapping, and it clears itself when software reads it. The 48-bit octet counter is read as two words. Reading the low word saves the upper 16 bits in a shadow register, so a later high-word read matches the low word already taken. A control register has a write-enable bit that lets software preload counters for test. It also has a self-clearing bit that adds one to every counter in a single cycle.

Top module: `mac_stat_bank`

## Requirements
- R1: A read of a counter register returns its value before the read in `reg_rdata` one cycle after `reg_rd`, and the counter is zero afterwards. Reading the low octet word (offset 0x4) clears all 48 bits. Reading the carrier-sense register (offset 0xC) clears that counter.
- R2: A counter that would pass its maximum (2^48-1 for octets, 2^10-1 for carrier-sense errors) stays at all ones. This holds for frame events, for the test increment, and for combinations of the two.
- R3: On each `rx_eof` strobe, the octet counter adds `rx_bytes`. Bits 31:0 read at offset 0x4 and bits 47:32 read in bits 15:0 at offset 0x8, with a carry moving from the low word into the high word.
- R4: A read at offset 0x4 copies counter bits 47:32 into a shadow register. Reads at offset 0x8 return that shadow, unaffected by counter activity after the low-word read.
- R5: Writes to counter registers change them only while control bit 7 (offset 0x0) is 1, and are ignored otherwise. A write to 0x4 loads bits 31:0, a write to 0x8 loads bits 47:32 from write-data bits 15:0, and a write to 0xC loads the carrier-sense counter. A load takes priority over any increment in the same cycle.
- R6: Writing 1 to control bit 6 adds exactly one to every counter one cycle later. The bit then clears itself and reads back as 0.
- R7: The carrier-sense counter occupies bits 9:0 at offset 0xC. Bits 31:10 read as zero and ignore written data.
- R8: A `tx_eof` strobe counts a carrier-sense error when either carrier was never seen (`tx_crs_seen`=0) or carrier dropped after being seen (`tx_crs_dropped`=1), and in both cases only if neither `tx_collision` nor `tx_underrun` is set.
- R9: Carrier-sense errors count only while `half_duplex` is 1. Counting one leaves the octet counter unchanged.
- R10: When a read-clear and an increment fall in the same cycle, the counter takes the increment amount, so no event is lost.
- R11: After reset all counters, the shadow, the control register (offset 0x0) and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Byte address of register (word aligned) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| rx_eof | input | 1 | End of a good received frame |
| rx_bytes | input | 16 | Byte count of that frame |
| tx_eof | input | 1 | End of a transmitted frame |
| tx_crs_seen | input | 1 | Carrier was seen during the frame |
| tx_crs_dropped | input | 1 | Carrier fell after having been seen |
| tx_collision | input | 1 | Frame suffered a collision |
| tx_underrun | input | 1 | Frame suffered an underrun |
| half_duplex | input | 1 | Link runs half duplex |

## Verification
A wrong counter value stays hidden until software reads that register. It then appears in `reg_rdata` in the cycle after the read, and it is never seen again, because the read clears it. For that reason each scenario follows its stimulus with a read, and then a second read that must return zero. A stale or missing high-word shadow only appears as a mismatch between the two halves of a 48-bit read. The bench forces a carry across bit 32 and injects traffic between the two reads to expose it.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int OCT_W      = 48;
  localparam int CRS_W      = 10;
  localparam int BYTES_W    = 16;
  localparam int CTRL_WREN  = 7;
  localparam int CTRL_INC   = 6;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_OCT_LO = 4;
  localparam int OFS_OCT_HI = 8;
  localparam int OFS_CRS    = 12;
endpackage

// File: rtl/mac_stat_sat_ctr.sv
module mac_stat_sat_ctr #(
  parameter int W  = 48,
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [W-1:0]  load_val_i,
  input  logic [AW-1:0] add_i,
  output logic [W-1:0]  cnt_o
);
  localparam int SW = W + 1;

  logic [W-1:0]  base;
  logic [SW-1:0] sum;

  always_comb begin
    base = clr_i ? '0 : cnt_o;
    sum  = {1'b0, base} + SW'(add_i);
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt_o <= '0;
    else if (load_i)    cnt_o <= load_val_i;
    else if (sum[W])    cnt_o <= '1;
    else                cnt_o <= sum[W-1:0];
  end

  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == '1 && !clr_i && !load_i) |=> cnt_o == '1);

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i) |=> cnt_o >= $past(cnt_o));

  // R10
  clr_add_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !load_i) |=> cnt_o == W'($past(add_i)));
endmodule

// File: rtl/mac_stat_ctrl.sv
module mac_stat_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic wren_bit_i,
  input  logic inc_bit_i,
  output logic wren_o,
  output logic inc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wren_o <= 1'b0;
      inc_o  <= 1'b0;
    end else begin
      if (wr_i) wren_o <= wren_bit_i;
      inc_o <= wr_i & inc_bit_i;
    end
  end

  // R6
  inc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_o && !(wr_i && inc_bit_i)) |=> !inc_o);
endmodule

// File: rtl/mac_stat_crs_qual.sv
module mac_stat_crs_qual (
  input  logic tx_eof_i,
  input  logic crs_seen_i,
  input  logic crs_dropped_i,
  input  logic collision_i,
  input  logic underrun_i,
  input  logic half_duplex_i,
  output logic evt_o
);
  logic carrier_bad;
  always_comb begin
    carrier_bad = !crs_seen_i || crs_dropped_i;
    evt_o = tx_eof_i && half_duplex_i && carrier_bad && !collision_i && !underrun_i;
  end
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               rx_eof,
  input  logic [BYTES_W-1:0] rx_bytes,
  input  logic               tx_eof,
  input  logic               tx_crs_seen,
  input  logic               tx_crs_dropped,
  input  logic               tx_collision,
  input  logic               tx_underrun,
  input  logic               half_duplex
);
  localparam int HI_W   = OCT_W - DATA_W;
  localparam int OAW    = BYTES_W + 1;
  localparam int CAW    = 2;

  logic sel_ctrl, sel_lo, sel_hi, sel_crs;
  logic wren, inc;
  logic crs_evt;
  logic [OCT_W-1:0] oct_cnt;
  logic [CRS_W-1:0] crs_cnt;
  logic [HI_W-1:0]  hi_q;
  logic [OAW-1:0]   oct_add;
  logic [CAW-1:0]   crs_add;
  logic             oct_load, crs_load;
  logic [OCT_W-1:0] oct_load_val;
  logic [DATA_W-1:0] ctrl_rd;

  always_comb begin
    sel_ctrl = reg_addr == ADDR_W'(OFS_CTRL);
    sel_lo   = reg_addr == ADDR_W'(OFS_OCT_LO);
    sel_hi   = reg_addr == ADDR_W'(OFS_OCT_HI);
    sel_crs  = reg_addr == ADDR_W'(OFS_CRS);
  end

  mac_stat_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (reg_wr && sel_ctrl),
    .wren_bit_i (reg_wdata[CTRL_WREN]),
    .inc_bit_i  (reg_wdata[CTRL_INC]),
    .wren_o     (wren),
    .inc_o      (inc)
  );

  mac_stat_crs_qual u_qual (
    .tx_eof_i      (tx_eof),
    .crs_seen_i    (tx_crs_seen),
    .crs_dropped_i (tx_crs_dropped),
    .collision_i   (tx_collision),
    .underrun_i    (tx_underrun),
    .half_duplex_i (half_duplex),
    .evt_o         (crs_evt)
  );

  always_comb begin
    oct_add      = (rx_eof ? OAW'(rx_bytes) : '0) + OAW'(inc);
    crs_add      = CAW'(crs_evt) + CAW'(inc);
    oct_load     = reg_wr && wren && (sel_lo || sel_hi);
    crs_load     = reg_wr && wren && sel_crs;
    oct_load_val = sel_lo ? {oct_cnt[OCT_W-1:DATA_W], reg_wdata}
                          : {reg_wdata[HI_W-1:0], oct_cnt[DATA_W-1:0]};
  end

  mac_stat_sat_ctr #(.W(OCT_W), .AW(OAW)) u_oct (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (reg_rd && sel_lo),
    .load_i     (oct_load),
    .load_val_i (oct_load_val),
    .add_i      (oct_add),
    .cnt_o      (oct_cnt)
  );

  mac_stat_sat_ctr #(.W(CRS_W), .AW(CAW)) u_crs (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (reg_rd && sel_crs),
    .load_i     (crs_load),
    .load_val_i (reg_wdata[CRS_W-1:0]),
    .add_i      (crs_add),
    .cnt_o      (crs_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)                  hi_q <= '0;
    else if (reg_rd && sel_lo) hi_q <= oct_cnt[OCT_W-1:DATA_W];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_WREN] = wren;
    ctrl_rd[CTRL_INC]  = inc;
  end

  always_ff @(posedge clk) begin
    if (rst || !reg_rd) reg_rdata <= '0;
    else if (sel_ctrl)  reg_rdata <= ctrl_rd;
    else if (sel_lo)    reg_rdata <= oct_cnt[DATA_W-1:0];
    else if (sel_hi)    reg_rdata <= DATA_W'(hi_q);
    else if (sel_crs)   reg_rdata <= DATA_W'(crs_cnt);
    else                reg_rdata <= '0;
  end

  // R4
  hi_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel_lo) |=> hi_q == $past(oct_cnt[OCT_W-1:DATA_W]));

  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && sel_lo) |=> $stable(hi_q));

  // R5
  wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !wren && sel_crs && !crs_evt && !inc && !reg_rd) |=> $stable(crs_cnt));

  // R9
  duplex_chk: assert property (@(posedge clk) disable iff (rst)
    (!half_duplex && !inc && !(reg_wr && wren) && !(reg_rd && sel_crs)) |=> $stable(crs_cnt));

  // R7
  crs_upper_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && sel_crs) |-> reg_rdata[DATA_W-1:CRS_W] == '0);
endmodule

// File: tb/mac_stat_bank_test.sv
module mac_stat_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_eof = 1'b0;
  logic [15:0] rx_bytes = '0;
  logic        tx_eof = 1'b0, tx_crs_seen = 1'b0, tx_crs_dropped = 1'b0;
  logic        tx_collision = 1'b0, tx_underrun = 1'b0, half_duplex = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mac_stat_bank uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_eof(rx_eof), .rx_bytes(rx_bytes),
    .tx_eof(tx_eof), .tx_crs_seen(tx_crs_seen), .tx_crs_dropped(tx_crs_dropped),
    .tx_collision(tx_collision), .tx_underrun(tx_underrun), .half_duplex(half_duplex)
  );

  localparam logic [3:0] A_CTRL = 4'h0, A_LO = 4'h4, A_HI = 4'h8, A_CRS = 4'hC;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_frame(input logic [15:0] n);
    @(negedge clk);
    rx_eof = 1'b1; rx_bytes = n;
    @(negedge clk);
    rx_eof = 1'b0; rx_bytes = '0;
  endtask

  task automatic tx_frame(input logic seen, input logic drop, input logic coll,
                          input logic urun, input logic half);
    @(negedge clk);
    tx_eof = 1'b1; tx_crs_seen = seen; tx_crs_dropped = drop;
    tx_collision = coll; tx_underrun = urun; half_duplex = half;
    @(negedge clk);
    tx_eof = 1'b0; tx_crs_seen = 1'b0; tx_crs_dropped = 1'b0;
    tx_collision = 1'b0; tx_underrun = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R11 rdata after reset", reg_rdata, 32'h0);
    do_read(A_CTRL, d); check("R11 ctrl reset", d, 32'h0);
    do_read(A_LO, d);   check("R11 octets low reset", d, 32'h0);
    do_read(A_HI, d);   check("R11 octets high reset", d, 32'h0);
    do_read(A_CRS, d);  check("R11 crs reset", d, 32'h0);
  endtask

  task automatic t_octets;
    logic [31:0] d;
    rx_frame(16'd100);
    rx_frame(16'd1500);
    do_read(A_LO, d); check("R3 octet sum", d, 32'd1600);
    do_read(A_HI, d); check("R3 octet high", d, 32'd0);
    do_read(A_LO, d); check("R1 octet cleared", d, 32'd0);
  endtask

  task automatic t_write_ignored;
    logic [31:0] d;
    do_write(A_CRS, 32'd5);
    do_write(A_LO, 32'h1234);
    do_read(A_CRS, d); check("R5 crs write ignored", d, 32'd0);
    do_read(A_LO, d);  check("R5 octet write ignored", d, 32'd0);
  endtask

  task automatic t_carry_and_latch;
    logic [31:0] d;
    do_write(A_CTRL, 32'h80);
    do_write(A_LO, 32'hFFFF_FFF0);
    do_write(A_HI, 32'h0000_0001);
    rx_frame(16'h0020);
    do_read(A_LO, d); check("R3 carry low word", d, 32'h10);
    rx_frame(16'd5);
    do_read(A_HI, d); check("R4 high shadow", d, 32'h2);
    do_read(A_LO, d); check("R1 new traffic after clear", d, 32'd5);
  endtask

  task automatic t_saturate;
    logic [31:0] d;
    do_write(A_LO, 32'hFFFF_FFFF);
    do_write(A_HI, 32'hFFFF_FFFF);
    rx_frame(16'd10);
    do_read(A_LO, d); check("R2 octet saturate low", d, 32'hFFFF_FFFF);
    do_read(A_HI, d); check("R2 octet saturate high", d, 32'h0000_FFFF);
    do_write(A_CRS, 32'hFFFF_FFFF);
    tx_frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    do_read(A_CRS, d); check("R7 crs upper bits zero, R2 saturate", d, 32'h3FF);
    do_read(A_CRS, d); check("R1 crs cleared", d, 32'h0);
    do_write(A_CTRL, 32'h0);
    do_read(A_LO, d); check("R1 octet cleared after saturation", d, 32'h0);
  endtask

  task automatic t_crs;
    logic [31:0] d;
    tx_frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    tx_frame(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    tx_frame(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    tx_frame(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    tx_frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tx_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    do_read(A_CRS, d); check("R8 R9 crs qualified count", d, 32'd2);
    do_read(A_LO, d);  check("R9 octets untouched by crs", d, 32'd0);
  endtask

  task automatic t_inc_all;
    logic [31:0] d;
    do_write(A_CTRL, 32'h40);
    repeat (2) @(negedge clk);
    do_read(A_CTRL, d); check("R6 inc bit self-clears", d, 32'h0);
    do_read(A_LO, d);   check("R6 octet +1", d, 32'd1);
    do_read(A_CRS, d);  check("R6 crs +1", d, 32'd1);
    do_write(A_CTRL, 32'h80);
    do_write(A_CRS, 32'h3FF);
    do_write(A_CTRL, 32'hC0);
    repeat (2) @(negedge clk);
    do_read(A_CRS, d);  check("R6 R2 inc at max", d, 32'h3FF);
    do_read(A_CTRL, d); check("R6 wren kept, inc clear", d, 32'h80);
    do_write(A_CTRL, 32'h0);
    do_read(A_LO, d);   check("R6 octet +1 again", d, 32'd1);
  endtask

  task automatic t_clear_collide;
    logic [31:0] d;
    rx_frame(16'd200);
    @(negedge clk);
    reg_addr = A_LO; reg_rd = 1'b1; rx_eof = 1'b1; rx_bytes = 16'd64;
    @(negedge clk);
    reg_rd = 1'b0; rx_eof = 1'b0; rx_bytes = '0;
    check("R10 read returns pre-clear", reg_rdata, 32'd200);
    do_read(A_LO, d); check("R10 same-cycle event kept", d, 32'd64);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_octets();
    t_write_ignored();
    t_carry_and_latch();
    t_saturate();
    t_crs();
    t_inc_all();
    t_clear_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule